// File: doc/BRIEF.md
# Flash Status Polling Completion Detector

This block sits on the host side of an asynchronous parallel flash bus. It decides when an embedded program or erase inside the flash has finished. Once `start` is seen, it counts the write strobes of the command sequence that the command issuer places on the bus. Only after the last strobe of that sequence does it begin issuing read cycles. Each read cycle is a single low pulse on the chip enable and output enable lines. The read address is fixed for the whole poll. For an erase, the caller must supply an address inside a sector that is being erased and is not protected.

Two completion tests are available. In toggle mode (`mode`=0), the block compares bit 6 of each read with bit 6 of the read before it. In data-poll mode (`mode`=1), it compares bit 7 of each read with bit 7 of the expected word. When either test is met, the block does one confirming read, because the status bit can settle before the other data bits do. The confirming word is captured. If it equals the expected word the block reports completion. If it does not, the block reports a protected-sector abort. A read budget bounds the poll, and running out of it raises a timeout.

States: `ST_IDLE` (waiting for start) → `ST_WAIT_WR` on start. `ST_WAIT_WR` (counting command strobes) → `ST_POLL` on the last strobe. `ST_POLL` (status reads) → `ST_CONFIRM` when the completion test is met, or → `ST_IDLE` with a timeout when the budget is spent. `ST_CONFIRM` (one full read) → `ST_IDLE`, reporting either done or abort.

Top module: `fpoll_top`

## Requirements
- R1: After an accepted `start`, `ce_n` and `oe_n` stay high until the command strobes have been counted on `wr_pulse`. The count is 4 strobes when `op_erase`=0 (program) and 6 strobes when `op_erase`=1 (erase). The first read begins only after the last of those strobes.
- R2: Each read drives `ce_n` and `oe_n` low together for exactly PULSE_CYC cycles, and `dq_in` is sampled at the end of that pulse. Both lines then stay high for at least GAP_CYC cycles. `addr` equals the `poll_addr` captured at start and never changes while `ce_n` is low.
- R3: Toggle mode (`mode`=0): the completion test is met at the first read whose bit 6 equals bit 6 of the read immediately before it in the same poll.
- R4: Data-poll mode (`mode`=1): the completion test is met at the first read whose bit 7 equals bit 7 of `exp_data`.
- R5: Once the completion test is met, exactly one more read is made. If that word equals `exp_data`, `done` pulses and `rd_data` takes that word.
- R6: If the confirming word differs from `exp_data`, `prot_abort` pulses and `rd_data` takes that word.
- R7: If the MAX_READS-th read of a poll does not meet the completion test, `tmo_err` pulses and no further reads are made. A test met on exactly the MAX_READS-th read still gets its confirming read.
- R8: `done`, `prot_abort` and `tmo_err` are one-cycle pulses, and at most one is high at a time. `rd_data` changes only together with `done` or `prot_abort`, so a timeout leaves the previous captured word in place.
- R9: A `start` that arrives while a poll is in progress is ignored. The mode, expected word and address of the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a poll |
| mode | input | 1 | 0 = toggle test on bit 6, 1 = data-poll test on bit 7 |
| op_erase | input | 1 | 0 = program (4 strobes), 1 = erase (6 strobes) |
| wr_pulse | input | 1 | One-cycle marker per completed command write strobe |
| poll_addr | input | AW | Address read during polling |
| exp_data | input | DW | Word expected after completion |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | AW | Bus address |
| dq_in | input | DW | Bus read data |
| done | output | 1 | Completion pulse |
| prot_abort | output | 1 | Protected-sector abort pulse |
| tmo_err | output | 1 | Read budget exhausted pulse |
| rd_data | output | DW | Last confirmed word |

## Verification
The bench builds the block with an 8-bit data bus, an 8-bit address, PULSE_CYC=2, GAP_CYC=1 and MAX_READS=12. With a budget that small, a sweep of the flash busy length from 0 to 13 reads covers every case. It reaches completion well inside the budget, a completion test met on exactly the last budgeted read, and timeouts, in both modes and for both program and erase strobe counts. Every busy length is also run with an unprotected and a protected final word. The modelled flash returns one settling read in which only bit 7 is already valid, so a confirming read that is skipped or misplaced shows up in `rd_data`.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_WR,
        ST_POLL,
        ST_CONFIRM
    } poll_st_e;

    typedef enum logic [1:0] {
        RC_IDLE,
        RC_LOW,
        RC_GAP
    } rc_ph_e;

    localparam int TOGGLE_BIT   = 6;
    localparam int POLL_BIT     = 7;
    localparam int PROG_STROBES = 4;
    localparam int ERASE_STROBES = 6;

endpackage

// File: rtl/fpoll_rdcyc.sv
module fpoll_rdcyc
    import fpoll_pkg::*;
#(
    parameter int DW        = 16,
    parameter int PULSE_CYC = 3,
    parameter int GAP_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [DW-1:0] dq_in,
    output logic          bus_n,
    output logic          smp_vld,
    output logic [DW-1:0] smp_data
);
    localparam int MAXC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    rc_ph_e        ph_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= RC_IDLE;
            cnt_q    <= '0;
            smp_vld  <= 1'b0;
            smp_data <= '0;
        end else begin
            smp_vld <= 1'b0;
            unique case (ph_q)
                RC_IDLE: begin
                    if (req) begin
                        ph_q  <= RC_LOW;
                        cnt_q <= '0;
                    end
                end
                RC_LOW: begin
                    if (cnt_q == CW'(PULSE_CYC - 1)) begin
                        smp_data <= dq_in;
                        smp_vld  <= 1'b1;
                        ph_q     <= RC_GAP;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RC_GAP: begin
                    if (cnt_q == CW'(GAP_CYC - 1)) begin
                        ph_q  <= RC_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ph_q <= RC_IDLE;
            endcase
        end
    end

    assign bus_n = (ph_q != RC_LOW);

    assert_sample_at_pulse_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_n) |-> smp_vld);

endmodule

// File: rtl/fpoll_wdog.sv
module fpoll_wdog #(
    parameter int MAX_READS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(MAX_READS + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(MAX_READS - 1));

    assert_read_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_READS + 1));

endmodule

// File: rtl/fpoll_fsm.sv
module fpoll_fsm
    import fpoll_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic          op_erase,
    input  logic          wr_pulse,
    input  logic [AW-1:0] poll_addr,
    input  logic [DW-1:0] exp_data,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_data,
    input  logic          last,
    output logic          req,
    output logic          wd_clr,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          prot_abort,
    output logic          tmo_err,
    output logic [DW-1:0] rd_data,
    output poll_st_e      st
);
    poll_st_e      nxt;
    logic          mode_q;
    logic          erase_q;
    logic [DW-1:0] exp_q;
    logic [2:0]    wr_cnt_q;
    logic          have_prev_q;
    logic          prev6_q;
    logic [2:0]    need;
    logic          hit;
    logic          match;

    assign need  = erase_q ? 3'(ERASE_STROBES) : 3'(PROG_STROBES);
    assign hit   = mode_q ? (smp_data[POLL_BIT] == exp_q[POLL_BIT])
                          : (have_prev_q && (smp_data[TOGGLE_BIT] == prev6_q));
    assign match = (smp_data == exp_q);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:    if (start) nxt = ST_WAIT_WR;
            ST_WAIT_WR: if (wr_pulse && (wr_cnt_q == need - 3'd1)) nxt = ST_POLL;
            ST_POLL: begin
                if (smp_vld) begin
                    if (hit)       nxt = ST_CONFIRM;
                    else if (last) nxt = ST_IDLE;
                end
            end
            ST_CONFIRM: if (smp_vld) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= 1'b0;
            erase_q     <= 1'b0;
            exp_q       <= '0;
            addr        <= '0;
            wr_cnt_q    <= '0;
            have_prev_q <= 1'b0;
            prev6_q     <= 1'b0;
            rd_data     <= '0;
            done        <= 1'b0;
            prot_abort  <= 1'b0;
            tmo_err     <= 1'b0;
        end else begin
            done       <= 1'b0;
            prot_abort <= 1'b0;
            tmo_err    <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        mode_q      <= mode;
                        erase_q     <= op_erase;
                        exp_q       <= exp_data;
                        addr        <= poll_addr;
                        wr_cnt_q    <= '0;
                        have_prev_q <= 1'b0;
                    end
                end
                ST_WAIT_WR: begin
                    if (wr_pulse) wr_cnt_q <= wr_cnt_q + 3'd1;
                end
                ST_POLL: begin
                    if (smp_vld) begin
                        prev6_q     <= smp_data[TOGGLE_BIT];
                        have_prev_q <= 1'b1;
                        if (!hit && last) tmo_err <= 1'b1;
                    end
                end
                ST_CONFIRM: begin
                    if (smp_vld) begin
                        rd_data    <= smp_data;
                        done       <= match;
                        prot_abort <= !match;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req    = (st == ST_POLL) || (st == ST_CONFIRM);
    assign wd_clr = (st == ST_IDLE) && start;

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, prot_abort, tmo_err}));

    assert_outcome_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done || prot_abort || tmo_err) |=> !(done || prot_abort || tmo_err));

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> (done || prot_abort));

    assert_outcome_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done || prot_abort) |-> (st == ST_IDLE));

endmodule

// File: rtl/fpoll_top.sv
module fpoll_top
    import fpoll_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 22,
    parameter int PULSE_CYC = 3,
    parameter int GAP_CYC   = 2,
    parameter int MAX_READS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    input  logic          op_erase,
    input  logic          wr_pulse,
    input  logic [AW-1:0] poll_addr,
    input  logic [DW-1:0] exp_data,
    output logic          ce_n,
    output logic          oe_n,
    output logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          done,
    output logic          prot_abort,
    output logic          tmo_err,
    output logic [DW-1:0] rd_data
);
    logic          req;
    logic          wd_clr;
    logic          bus_n;
    logic          smp_vld;
    logic [DW-1:0] smp_data;
    logic          last;
    poll_st_e      st;

    fpoll_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .op_erase   (op_erase),
        .wr_pulse   (wr_pulse),
        .poll_addr  (poll_addr),
        .exp_data   (exp_data),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .last       (last),
        .req        (req),
        .wd_clr     (wd_clr),
        .addr       (addr),
        .done       (done),
        .prot_abort (prot_abort),
        .tmo_err    (tmo_err),
        .rd_data    (rd_data),
        .st         (st)
    );

    fpoll_rdcyc #(.DW(DW), .PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_rdcyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .dq_in    (dq_in),
        .bus_n    (bus_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data)
    );

    fpoll_wdog #(.MAX_READS(MAX_READS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wd_clr),
        .tick  (smp_vld),
        .last  (last)
    );

    assign ce_n = bus_n;
    assign oe_n = bus_n;

    assert_addr_steady_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |-> $stable(addr));

    assert_min_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |=> ce_n);

    assert_no_read_before_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_WR) |-> ce_n);

endmodule

// File: tb/fpoll_top_tb_top.sv
module fpoll_top_tb_top;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int PC = 2;
    localparam int GC = 1;
    localparam int MR = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic          op_erase = 1'b0;
    logic          wr_pulse = 1'b0;
    logic [AW-1:0] poll_addr = '0;
    logic [DW-1:0] exp_data = '0;
    logic          ce_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in;
    logic          done, prot_abort, tmo_err;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rd_idx = 0;
    int low_len = 0;
    int high_len = 0;
    logic prev_oe = 1'b1;
    int cur_b = 0;
    logic [7:0] cur_fin = '0;
    logic [7:0] cur_exp = '0;
    logic [7:0] prev_cap = '0;

    always #10 clk = ~clk;

    fpoll_top #(.DW(DW), .AW(AW), .PULSE_CYC(PC), .GAP_CYC(GC), .MAX_READS(MR)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op_erase(op_erase),
        .wr_pulse(wr_pulse), .poll_addr(poll_addr), .exp_data(exp_data),
        .ce_n(ce_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .done(done), .prot_abort(prot_abort), .tmo_err(tmo_err), .rd_data(rd_data)
    );

    // Flash model: busy reads toggle bit 6 and invert bit 7; one settling read
    // where only bit 7 is final; then the final word.
    function automatic logic [7:0] word_of(int k, int b, logic [7:0] fin, logic [7:0] ex);
        logic [7:0] w;
        if (k <= b) begin
            w = ~ex;
            w[6] = k[0];
        end else if (k == b + 1) begin
            w = ~fin;
            w[7] = fin[7];
        end else begin
            w = fin;
        end
        return w;
    endfunction

    assign dq_in = word_of(rd_idx + 1, cur_b, cur_fin, cur_exp);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Bus monitor: pulse length, gap and address per read (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_oe && !oe_n) begin
                if (rd_idx > 0) chk(high_len >= GC, "R2 gap", high_len, GC);
                chk(addr == poll_addr && ce_n == oe_n, "R2 addr", addr, poll_addr);
                low_len = 1;
            end else if (!oe_n) begin
                low_len++;
            end else if (!prev_oe && oe_n) begin
                chk(low_len == PC, "R2 pulse", low_len, PC);
                rd_idx++;
                high_len = 1;
            end else begin
                high_len++;
            end
            prev_oe = oe_n;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_case(input bit md, input bit er, input int b, input bit prot, input bit inject);
        int need;
        int total;
        int kind;
        int waitc;
        int got_reads;
        logic [7:0] cw;
        logic [7:0] ex;
        ex = 8'hA5 ^ 8'(b * 37) ^ {7'd0, md};
        cur_exp = ex;
        cur_fin = prot ? (ex ^ 8'h0F) : ex;
        cur_b = b;
        // expected result from the requirements
        total = MR; kind = 2; cw = 8'h00;
        for (int k = 1; k <= MR; k++) begin
            bit h;
            if (md) h = (word_of(k, b, cur_fin, ex)[7] == ex[7]);
            else    h = (k >= 2) && (word_of(k, b, cur_fin, ex)[6] == word_of(k - 1, b, cur_fin, ex)[6]);
            if (h) begin
                total = k + 1;
                cw = word_of(k + 1, b, cur_fin, ex);
                kind = (cw == ex) ? 0 : 1;
                break;
            end
        end
        need = er ? 6 : 4;
        @(negedge clk);
        rd_idx = 0;
        mode = md; op_erase = er; exp_data = ex;
        poll_addr = 8'(8'h30 + b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < need; i++) begin
            if (i == need - 1) begin
                repeat (3) @(negedge clk);
                chk(rd_idx == 0 && oe_n && ce_n, "R1 no read before last strobe", rd_idx, 0);
            end
            wr_pulse = 1'b1;
            @(negedge clk);
            wr_pulse = 1'b0;
            @(negedge clk);
        end
        if (inject) begin
            while (rd_idx < 2) @(negedge clk);
            start = 1'b1; exp_data = ~ex; mode = ~md; poll_addr = 8'hFF;
            @(negedge clk);
            start = 1'b0; exp_data = ex; mode = md; poll_addr = 8'(8'h30 + b);
        end
        waitc = 0;
        while (!(done || prot_abort || tmo_err) && waitc < 3000) begin
            @(negedge clk);
            waitc++;
        end
        got_reads = rd_idx;
        if (kind == 0) begin
            chk(done && !prot_abort && !tmo_err, md ? "R4 R5 done" : "R3 R5 done",
                {done, prot_abort, tmo_err}, 3'b100);
            chk(rd_data == ex, "R5 captured word", rd_data, ex);
        end else if (kind == 1) begin
            chk(prot_abort && !done && !tmo_err, "R6 abort", {done, prot_abort, tmo_err}, 3'b010);
            chk(rd_data == cur_fin, "R6 captured word", rd_data, cur_fin);
        end else begin
            chk(tmo_err && !done && !prot_abort, "R7 timeout", {done, prot_abort, tmo_err}, 3'b001);
            chk(rd_data == prev_cap, "R8 hold on timeout", rd_data, prev_cap);
        end
        chk(got_reads == total, md ? "R4 read count" : "R3 read count", got_reads, total);
        if (inject) chk(kind != 2 && got_reads == total, "R9 start ignored", got_reads, total);
        @(negedge clk);
        chk(!(done || prot_abort || tmo_err), "R8 single cycle", {done, prot_abort, tmo_err}, 0);
        if (kind != 2) prev_cap = rd_data;
        repeat (6) @(negedge clk);
        chk(rd_idx == got_reads, "R7 no reads after outcome", rd_idx, got_reads);
        chk(rd_data == prev_cap, "R8 rd_data held", rd_data, prev_cap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n, "R2 reset bus idle", {ce_n, oe_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !prot_abort && !tmo_err, "R8 reset outcomes", {done, prot_abort, tmo_err}, 0);
        chk(rd_data == '0 && ce_n, "R8 reset capture", rd_data, 0);
        for (int md = 0; md < 2; md++)
            for (int b = 0; b < 14; b++)
                for (int p = 0; p < 2; p++)
                    run_case(md[0], b[0], b, p[0], 1'b0);
        run_case(1'b0, 1'b0, 5, 1'b0, 1'b1);
        run_case(1'b1, 1'b1, 4, 1'b0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule